// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Read Cache

This block is the load side of a set-associative first-level data cache whose set is chosen before address translation has finished. Only the untranslated page-offset bits of the virtual address are presented to it. They pick both the set and the 8-byte word inside the line. The tags and the selected word of every way in that set are read at once. The physical page number arrives later from a separate translation unit, and the tag compare runs in the cycle that the translation result is marked valid. A match returns the word. A mismatch asks the next level for the whole line at its physical line address and writes the returned line into a victim way. A translation fault abandons the access without a response word and without a refill.

With the default parameters, a 4 KiB page offset is split into a 6-bit set index and a 6-bit byte position within a 64-byte line. This gives 64 sets of 8 ways, and the full 40-bit physical page number serves as the tag. One access is handled at a time. The request port is ready again once the access has resolved.

Top module: `vipt_l1_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` is 1, and `rsp_valid`, `rsp_fault` and `fill_req_valid` are 0.
- R2: A request is taken on a clock edge where `cpu_req_valid` and `cpu_req_ready` are both 1. Offset bits [11:6] select the set and bits [5:3] select the 8-byte word. `cpu_req_ready` is 0 from the following cycle until the access resolves.
- R3: When `xl_valid` is sampled high during a lookup, with `xl_fault` low and a valid way whose tag equals `xl_ppn`, `rsp_valid` is 1 for exactly the next cycle and no refill is requested.
- R4: The returned word for word select w is bits [64*w+63 : 64*w] of the stored line (byte 0 of the line is the least significant byte).
- R5: On a lookup that finds no matching valid way, `fill_req_valid` rises in the next cycle. `fill_req_line` then equals {ppn, set}, with the page number in the upper 40 bits and the set in the lower 6 bits. Both stay unchanged until `fill_valid` is sampled.
- R6: In the cycle after `fill_valid` is sampled, `rsp_valid` is 1 with word w of `fill_data`, `fill_req_valid` is 0 and the port is ready again. Later reads of that line hit, and a line never occupies two ways of a set.
- R7: A lookup sampled with `xl_valid` and `xl_fault` both high gives `rsp_fault` for one cycle, with no `rsp_valid` and no refill request. Resident lines stay resident.
- R8: The victim is the lowest-numbered invalid way of the set. If all ways are valid, the victim comes from a 7-node binary tree kept per set: the root and then one node per level choose the upper half when 1 and the lower half when 0. Every hit and every refill sets each node on the path to the used way so that it points away from that way. All nodes are 0 after reset.
- R9: While a lookup waits with `xl_valid` low, no response and no refill request appear, and the lookup stays pending. `cpu_req_valid` has no effect while `cpu_req_ready` is 0.
- R10: The tag compare uses all 40 page-number bits. A page number that differs in any single bit, including the top one, misses. The same page number in another set also misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req_valid | input | 1 | Read request present |
| cpu_req_ready | output | 1 | Request port can accept |
| cpu_req_vofs | input | 9 | Page-offset bits [11:3] of the virtual address |
| xl_valid | input | 1 | Translation result valid |
| xl_ppn | input | 40 | Physical page number from translation |
| xl_fault | input | 1 | Translation failed; abandon the access |
| rsp_valid | output | 1 | Read word returned (one-cycle pulse) |
| rsp_fault | output | 1 | Access abandoned on a fault (one-cycle pulse) |
| rsp_data | output | 64 | Returned 8-byte word |
| fill_req_valid | output | 1 | Line refill requested |
| fill_req_line | output | 46 | Physical line address {ppn, set} |
| fill_valid | input | 1 | Refill line present |
| fill_data | input | 512 | Refill line, byte 0 least significant |

## Verification
A cold miss, followed by hits to several words of the same line, separates a correct word select from a correct set select. Translation that arrives several cycles late shows that the lookup waits without producing output. Page numbers that differ only in their top bit, and a resident page number presented with another set, show whether the whole tag and the offset-only index are both in use. Faults raised on a resident line and on an absent line separate abandoning the access from refilling or invalidating. Filling one set past its eight ways, with hits interleaved, checks each victim choice against an independent model of invalid-first tree replacement.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  // Access sequencer: idle, waiting for translation, waiting for the line.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_REFILL = 2'd2
  } lk_state_e;

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter  int SETS  = 64,
  parameter  int WAYS  = 8,
  parameter  int TAG_W = 40,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [SET_W-1:0] rd_set,
  output logic [TAG_W-1:0] rd_tag [WAYS],
  output logic [WAYS-1:0]  rd_vld,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tags [SETS];
    logic [SETS-1:0]  vld;
    logic [TAG_W-1:0] tag_q;
    logic             vld_q;
    logic             sel;

    assign sel = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk) begin
      if (sel) tags[wr_set] <= wr_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld   <= '0;
        vld_q <= 1'b0;
      end else begin
        if (sel)   vld[wr_set] <= 1'b1;
        if (rd_en) vld_q       <= vld[rd_set];
      end
    end

    always_ff @(posedge clk) begin
      if (rd_en) tag_q <= tags[rd_set];
    end

    assign rd_tag[w] = tag_q;
    assign rd_vld[w] = vld_q;
  end

endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter  int SETS   = 64,
  parameter  int WAYS   = 8,
  parameter  int LINE_W = 512,
  parameter  int WORD_W = 64,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WSEL_W = $clog2(LINE_W / WORD_W)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WSEL_W-1:0] rd_wsel,
  output logic [WORD_W-1:0] rd_word [WAYS],
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [LINE_W-1:0] wr_line
);

  // Only the selected word of each way is read out, not the whole line.
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_W-1:0] lines [SETS];
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == WAY_W'(w))) lines[wr_set] <= wr_line;
      if (rd_en) word_q <= lines[rd_set][rd_wsel*WORD_W +: WORD_W];
    end

    assign rd_word[w] = word_q;
  end

endmodule

// File: rtl/vipt_plru.sv
module vipt_plru #(
  parameter  int SETS  = 64,
  parameter  int WAYS  = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] q_set,
  output logic [WAY_W-1:0] q_victim,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way
);

  // Heap numbering: node n (1-based) is bit n-1; children of n are 2n, 2n+1.
  function automatic logic [WAY_W-1:0] tree_victim(input logic [NODES-1:0] t);
    int n;
    n = 1;
    for (int l = 0; l < WAY_W; l++) n = 2 * n + int'(t[n-1]);
    return WAY_W'(n - WAYS);
  endfunction

  function automatic logic [NODES-1:0] tree_touch(input logic [NODES-1:0] t,
                                                  input logic [WAY_W-1:0] way);
    logic [NODES-1:0] r;
    int n;
    r = t;
    n = WAYS + int'(way);
    for (int l = 0; l < WAY_W; l++) begin
      r[(n >> 1) - 1] = ~n[0];
      n = n >> 1;
    end
    return r;
  endfunction

  logic [NODES-1:0] st [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) st[i] <= '0;
    end else if (touch_en) begin
      st[touch_set] <= tree_touch(st[touch_set], touch_way);
    end
  end

  assign q_victim = tree_victim(st[q_set]);

endmodule

// File: rtl/vipt_l1_cache.sv
module vipt_l1_cache
  import vipt_pkg::*;
#(
  parameter  int PPN_W       = 40,
  parameter  int PAGE_OFS_W  = 12,
  parameter  int LINE_BYTES  = 64,
  parameter  int WAYS        = 8,
  parameter  int WORD_BYTES  = 8,
  localparam int LINE_OFS_W  = $clog2(LINE_BYTES),
  localparam int BYTE_W      = $clog2(WORD_BYTES),
  localparam int SET_W       = PAGE_OFS_W - LINE_OFS_W,
  localparam int SETS        = 1 << SET_W,
  localparam int WSEL_W      = LINE_OFS_W - BYTE_W,
  localparam int LINE_W      = LINE_BYTES * 8,
  localparam int WORD_W      = WORD_BYTES * 8,
  localparam int WAY_W       = $clog2(WAYS),
  localparam int LINE_ADDR_W = PPN_W + SET_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_req_valid,
  output logic                        cpu_req_ready,
  input  logic [PAGE_OFS_W-1:BYTE_W]  cpu_req_vofs,
  input  logic                        xl_valid,
  input  logic [PPN_W-1:0]            xl_ppn,
  input  logic                        xl_fault,
  output logic                        rsp_valid,
  output logic                        rsp_fault,
  output logic [WORD_W-1:0]           rsp_data,
  output logic                        fill_req_valid,
  output logic [LINE_ADDR_W-1:0]      fill_req_line,
  input  logic                        fill_valid,
  input  logic [LINE_W-1:0]           fill_data
);

  // Lowest-numbered clear bit of a valid vector (caller ensures one exists).
  function automatic logic [WAY_W-1:0] lowest_free(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (!v[i]) r = WAY_W'(i);
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] line_word(input logic [LINE_W-1:0] ln,
                                                  input logic [WSEL_W-1:0] ws);
    return ln[ws*WORD_W +: WORD_W];
  endfunction

  lk_state_e          state_q;
  logic [SET_W-1:0]   set_q;
  logic [WSEL_W-1:0]  wsel_q;
  logic [PPN_W-1:0]   ppn_q;
  logic [WAY_W-1:0]   way_q;

  logic [SET_W-1:0]   req_set;
  logic [WSEL_W-1:0]  req_wsel;
  logic               accept;

  // Named events, brought out for the checker.
  logic               lookup_fire;
  logic               hit_fire;
  logic               miss_fire;
  logic               abort_fire;
  logic               refill_fire;

  logic [PPN_W-1:0]   rd_tag  [WAYS];
  logic [WAYS-1:0]    rd_vld;
  logic [WORD_W-1:0]  rd_word [WAYS];
  logic [WAYS-1:0]    hit_vec;
  logic [WORD_W-1:0]  hit_word;
  logic [WAY_W-1:0]   hit_idx;
  logic [WAY_W-1:0]   tree_way;
  logic [WAY_W-1:0]   victim_way;
  logic               touch_en;
  logic [WAY_W-1:0]   touch_way;

  // Index and word select come from the page offset alone.
  assign req_set  = cpu_req_vofs[PAGE_OFS_W-1:LINE_OFS_W];
  assign req_wsel = cpu_req_vofs[LINE_OFS_W-1:BYTE_W];

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;

  assign lookup_fire = (state_q == ST_LOOKUP) && xl_valid;
  assign abort_fire  = lookup_fire && xl_fault;
  assign hit_fire    = lookup_fire && !xl_fault && (|hit_vec);
  assign miss_fire   = lookup_fire && !xl_fault && !(|hit_vec);
  assign refill_fire = (state_q == ST_REFILL) && fill_valid;

  vipt_tag_store #(
    .SETS (SETS),
    .WAYS (WAYS),
    .TAG_W(PPN_W)
  ) u_tags (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (accept),
    .rd_set(req_set),
    .rd_tag(rd_tag),
    .rd_vld(rd_vld),
    .wr_en (refill_fire),
    .wr_set(set_q),
    .wr_way(way_q),
    .wr_tag(ppn_q)
  );

  vipt_data_store #(
    .SETS  (SETS),
    .WAYS  (WAYS),
    .LINE_W(LINE_W),
    .WORD_W(WORD_W)
  ) u_data (
    .clk    (clk),
    .rd_en  (accept),
    .rd_set (req_set),
    .rd_wsel(req_wsel),
    .rd_word(rd_word),
    .wr_en  (refill_fire),
    .wr_set (set_q),
    .wr_way (way_q),
    .wr_line(fill_data)
  );

  // Physical tag compare, one comparator per way.
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = rd_vld[w] && (rd_tag[w] == xl_ppn);
  end

  always_comb begin
    hit_word = '0;
    hit_idx  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_word = hit_word | rd_word[w];
        hit_idx  = hit_idx | WAY_W'(w);
      end
    end
  end

  assign touch_en  = hit_fire || refill_fire;
  assign touch_way = hit_fire ? hit_idx : way_q;

  vipt_plru #(
    .SETS(SETS),
    .WAYS(WAYS)
  ) u_plru (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_set    (set_q),
    .q_victim (tree_way),
    .touch_en (touch_en),
    .touch_set(set_q),
    .touch_way(touch_way)
  );

  assign victim_way = (&rd_vld) ? tree_way : lowest_free(rd_vld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      set_q          <= '0;
      wsel_q         <= '0;
      ppn_q          <= '0;
      way_q          <= '0;
      rsp_valid      <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_data       <= '0;
      fill_req_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            set_q   <= req_set;
            wsel_q  <= req_wsel;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (abort_fire) begin
            rsp_fault <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (hit_fire) begin
            rsp_valid <= 1'b1;
            rsp_data  <= hit_word;
            state_q   <= ST_IDLE;
          end else if (miss_fire) begin
            fill_req_valid <= 1'b1;
            ppn_q          <= xl_ppn;
            way_q          <= victim_way;
            state_q        <= ST_REFILL;
          end
        end
        ST_REFILL: begin
          if (refill_fire) begin
            fill_req_valid <= 1'b0;
            rsp_valid      <= 1'b1;
            rsp_data       <= line_word(fill_data, wsel_q);
            state_q        <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fill_req_line = {ppn_q, set_q};

endmodule

// File: rtl/vipt_l1_checker.sv
module vipt_l1_checker #(
  parameter int WAYS        = 8,
  parameter int LINE_ADDR_W = 46
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cpu_req_valid,
  input logic                   cpu_req_ready,
  input logic                   lookup_fire,
  input logic                   hit_fire,
  input logic                   miss_fire,
  input logic                   abort_fire,
  input logic                   refill_fire,
  input logic [WAYS-1:0]        hit_vec,
  input logic                   rsp_valid,
  input logic                   rsp_fault,
  input logic                   fill_req_valid,
  input logic [LINE_ADDR_W-1:0] fill_req_line,
  input logic                   fill_valid
);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);

  assert_hit_responds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> rsp_valid && !rsp_fault && !fill_req_valid);

  assert_rsp_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_fault));

  assert_miss_requests_R5: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> fill_req_valid && !rsp_valid && !rsp_fault);

  assert_fill_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid && !fill_valid |=> fill_req_valid && $stable(fill_req_line));

  assert_refill_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refill_fire |=> rsp_valid && !fill_req_valid && cpu_req_ready);

  assert_single_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_fire |-> $onehot0(hit_vec));

  assert_fault_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_fire |=> rsp_fault && !rsp_valid && !fill_req_valid && cpu_req_ready);

endmodule

bind vipt_l1_cache vipt_l1_checker #(
  .WAYS       (WAYS),
  .LINE_ADDR_W(LINE_ADDR_W)
) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .lookup_fire   (lookup_fire),
  .hit_fire      (hit_fire),
  .miss_fire     (miss_fire),
  .abort_fire    (abort_fire),
  .refill_fire   (refill_fire),
  .hit_vec       (hit_vec),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .fill_req_valid(fill_req_valid),
  .fill_req_line (fill_req_line),
  .fill_valid    (fill_valid)
);

// File: tb/tb_vipt_l1_cache.sv
module tb_vipt_l1_cache;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req_valid = 1'b0;
  logic         cpu_req_ready;
  logic [11:3]  cpu_req_vofs = '0;
  logic         xl_valid = 1'b0;
  logic [39:0]  xl_ppn = '0;
  logic         xl_fault = 1'b0;
  logic         rsp_valid;
  logic         rsp_fault;
  logic [63:0]  rsp_data;
  logic         fill_req_valid;
  logic [45:0]  fill_req_line;
  logic         fill_valid = 1'b0;
  logic [511:0] fill_data = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vipt_l1_cache dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_vofs  (cpu_req_vofs),
    .xl_valid      (xl_valid),
    .xl_ppn        (xl_ppn),
    .xl_fault      (xl_fault),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_data      (rsp_data),
    .fill_req_valid(fill_req_valid),
    .fill_req_line (fill_req_line),
    .fill_valid    (fill_valid),
    .fill_data     (fill_data)
  );

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  // Reference model: per-set tags, valid flags and replacement tree.
  logic [39:0] m_tag  [64][8];
  bit          m_vld  [64][8];
  logic [6:0]  m_tree [64];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pat_word(input logic [39:0] p, input int s, input int k);
    return {p[31:0], 2'b00, 6'(s), 5'b00000, 3'(k), 16'hC0DE};
  endfunction

  function automatic logic [511:0] pat_line(input logic [39:0] p, input int s);
    logic [511:0] l;
    for (int k = 0; k < 8; k++) l[64*k +: 64] = pat_word(p, s, k);
    return l;
  endfunction

  function automatic int m_find(input logic [39:0] p, input int s);
    int r;
    r = -1;
    for (int w = 0; w < 8; w++) if (m_vld[s][w] && m_tag[s][w] == p) r = w;
    return r;
  endfunction

  // R8 restated: level bits of the way index address the tree nodes.
  function automatic void m_touch(input int s, input int way);
    logic [2:0] w;
    w = 3'(way);
    m_tree[s][0]                     = ~w[2];
    m_tree[s][1 + int'(w[2])]        = ~w[1];
    m_tree[s][3 + int'({w[2], w[1]})] = ~w[0];
  endfunction

  function automatic int m_victim(input int s);
    logic v2, v1, v0;
    for (int w = 0; w < 8; w++) if (!m_vld[s][w]) return w;
    v2 = m_tree[s][0];
    v1 = m_tree[s][1 + int'(v2)];
    v0 = m_tree[s][3 + int'({v2, v1})];
    return int'({v2, v1, v0});
  endfunction

  // One read access, predicted and checked against the model.
  task automatic do_read(input logic [39:0] p, input int s, input int wd,
                         input bit flt, input int dly, input int rdly,
                         input bit poke, input string rq);
    int hw;
    int v;
    hw = m_find(p, s);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_vofs  = {6'(s), 3'(wd)};
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk(cpu_req_ready == 1'b0, "R2", "ready after accept", 64'(cpu_req_ready), 64'd0);
    for (int i = 0; i < dly; i++) begin
      chk(!rsp_valid && !rsp_fault && !fill_req_valid, "R9", "quiet while untranslated",
          {61'd0, rsp_valid, rsp_fault, fill_req_valid}, 64'd0);
      @(negedge clk);
    end
    xl_valid = 1'b1;
    xl_ppn   = p;
    xl_fault = flt;
    @(negedge clk);
    xl_valid = 1'b0;
    xl_fault = 1'b0;
    if (flt) begin
      chk(rsp_fault == 1'b1, {"R7 ", rq}, "fault pulse", 64'(rsp_fault), 64'd1);
      chk(!rsp_valid && !fill_req_valid, {"R7 ", rq}, "no data, no refill",
          {62'd0, rsp_valid, fill_req_valid}, 64'd0);
    end else if (hw >= 0) begin
      chk(rsp_valid == 1'b1 && !fill_req_valid, {"R3 ", rq}, "hit response",
          {62'd0, rsp_valid, fill_req_valid}, 64'd2);
      chk(rsp_data == pat_word(p, s, wd), {"R4 ", rq}, "hit word", rsp_data, pat_word(p, s, wd));
      m_touch(s, hw);
    end else begin
      chk(fill_req_valid == 1'b1 && !rsp_valid, {"R5 ", rq}, "refill request",
          {62'd0, fill_req_valid, rsp_valid}, 64'd2);
      chk(fill_req_line == {p, 6'(s)}, "R5", "line address", 64'(fill_req_line), 64'({p, 6'(s)}));
      for (int i = 0; i < rdly; i++) begin
        if (poke) begin
          cpu_req_valid = 1'b1;
          cpu_req_vofs  = ~cpu_req_vofs;
        end
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk(fill_req_valid && fill_req_line == {p, 6'(s)} && !cpu_req_ready, "R9",
            "request held, port busy", 64'(fill_req_line), 64'({p, 6'(s)}));
      end
      fill_valid = 1'b1;
      fill_data  = pat_line(p, s);
      @(negedge clk);
      fill_valid = 1'b0;
      fill_data  = '0;
      chk(rsp_valid && !fill_req_valid && cpu_req_ready, "R6", "refill completion",
          {61'd0, rsp_valid, fill_req_valid, cpu_req_ready}, 64'd5);
      chk(rsp_data == pat_word(p, s, wd), "R6", "refill word", rsp_data, pat_word(p, s, wd));
      v = m_victim(s);
      m_tag[s][v] = p;
      m_vld[s][v] = 1'b1;
      m_touch(s, v);
    end
    chk(cpu_req_ready == 1'b1, "R2", "ready after resolve", 64'(cpu_req_ready), 64'd1);
  endtask

  task automatic t_reset();
    chk(cpu_req_ready == 1'b1, "R1", "ready after reset", 64'(cpu_req_ready), 64'd1);
    chk(!rsp_valid && !rsp_fault && !fill_req_valid, "R1", "outputs idle",
        {61'd0, rsp_valid, rsp_fault, fill_req_valid}, 64'd0);
  endtask

  task automatic t_cold_and_words();
    logic [39:0] a;
    a = 40'h12_3456_789A;
    do_read(a, 3, 2, 1'b0, 0, 2, 1'b0, "cold");
    do_read(a, 3, 0, 1'b0, 0, 0, 1'b0, "word0");
    do_read(a, 3, 7, 1'b0, 0, 0, 1'b0, "word7");
    do_read(a, 3, 5, 1'b0, 3, 0, 1'b0, "late translation R9");
  endtask

  task automatic t_fault();
    logic [39:0] a, b;
    a = 40'h12_3456_789A;
    b = 40'h00_0BAD_0001;
    do_read(a, 3, 1, 1'b1, 1, 0, 1'b0, "fault resident");
    do_read(a, 3, 1, 1'b0, 0, 0, 1'b0, "R7 still resident");
    do_read(b, 3, 4, 1'b1, 0, 0, 1'b0, "fault absent");
    do_read(b, 3, 4, 1'b0, 0, 1, 1'b0, "R7 absent stays absent");
  endtask

  task automatic t_tag_width();
    logic [39:0] a;
    a = 40'h12_3456_789A;
    do_read(a ^ 40'h80_0000_0000, 3, 6, 1'b0, 0, 0, 1'b0, "R10 top bit differs");
    do_read(a, 4, 6, 1'b0, 0, 0, 1'b0, "R10 other set");
    do_read(a, 3, 6, 1'b0, 0, 0, 1'b0, "R10 original");
  endtask

  task automatic t_busy_ignore();
    do_read(40'h55_0000_1234, 17, 3, 1'b0, 2, 3, 1'b1, "R9 poke while busy");
    do_read(40'h55_0000_1234, 17, 3, 1'b0, 0, 0, 1'b0, "R9 after poke");
  endtask

  task automatic t_evict();
    logic [39:0] p [10];
    for (int i = 0; i < 10; i++) p[i] = 40'hA0_0000_0000 + 40'(i) * 40'h1_0001;
    for (int i = 0; i < 8; i++) do_read(p[i], 9, i % 8, 1'b0, 0, 0, 1'b0, "R8 fill");
    do_read(p[2], 9, 1, 1'b0, 0, 0, 1'b0, "R8 touch");
    do_read(p[5], 9, 6, 1'b0, 0, 0, 1'b0, "R8 touch");
    do_read(p[8], 9, 0, 1'b0, 0, 0, 1'b0, "R8 evict");
    do_read(p[9], 9, 7, 1'b0, 0, 0, 1'b0, "R8 evict");
    for (int i = 0; i < 10; i++) do_read(p[i], 9, 3, 1'b0, 0, 0, 1'b0, "R8 revisit");
  endtask

  initial begin
    for (int s = 0; s < 64; s++) begin
      m_tree[s] = '0;
      for (int w = 0; w < 8; w++) begin
        m_vld[s][w] = 1'b0;
        m_tag[s][w] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_and_words();
    t_fault();
    t_tag_width();
    t_busy_ignore();
    t_evict();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule